// File: doc/BRIEF.md
# Framed serial transmitter with enable gating

This block converts bytes written by a host into a serial bit stream on `txd`. The pace is set by a transmit clock `txc`. This clock is sampled in the system clock domain, and every falling edge of `txc` is one step of the shifter. In synchronous mode one data bit goes out per `txc` period, with no framing. In asynchronous mode each character goes out as a frame: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Each bit lasts 1, 16 or 64 `txc` periods.

Storage is one holding register in front of a frame shifter. Bytes enter through a valid/ready handshake: `in_ready` is high exactly while the holding register is empty, and a byte moves on every cycle in which `in_valid` and `in_ready` are both high. The host may hold `in_valid` high for as long as it likes. The enable gate is evaluated at the moment a byte is accepted. A byte accepted while the gate is open is always sent in full, even if the gate closes later. A byte accepted while the gate is closed is discarded. The plain outputs `tx_ready` and `tx_empty` report the state of the holding register and the shifter. A break input forces the line low.

Top module: `serial_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1 and `in_ready` is 1. `tx_ready` is 1 when `tx_en`=1 and `cts_n`=0.
- R2: `txd` changes only in the system clock cycle that follows a falling edge of `txc`. It holds steady through the whole high phase of `txc`.
- R3: When `cfg_sync`=1, a character goes out as 5+`cfg_len` data bits, least significant first, one bit per `txc` period. The parity bit follows when `cfg_par_en`=1. There are no start or stop bits.
- R4: When `cfg_sync`=0, each bit lasts a number of `txc` periods set by `cfg_rate`: 0 gives 1, 1 gives 16, and 2 or 3 gives 64.
- R5: An asynchronous frame is a start bit of 0, then 5+`cfg_len` data bits LSB first, then the parity bit if enabled, then the stop bits of 1 (two when `cfg_two_stop`=1, otherwise one). The parity bit makes the count of ones over data plus parity even when `cfg_par_odd`=0, and odd when it is 1.
- R6: `in_ready` equals "holding register empty". It falls in the cycle after an accepted byte.
- R7: `tx_ready` is 1 only while the holding register is empty, `tx_en`=1 and `cts_n`=0.
- R8: A byte accepted while enabled is sent completely, even if `cts_n` rises or `tx_en` falls right after acceptance.
- R9: A byte accepted while disabled is never sent: `txd` stays 1 and `tx_empty` stays 1, also after the enable returns.
- R10: `tx_empty` is 1 exactly when the shifter is idle and the holding register is empty. It is 0 throughout a frame.
- R11: While `brk`=1, `txd` is 0, whether the line is idle or in the middle of a frame.
- R12: A byte waiting in the holding register starts on the same `txc` falling edge that ends the last bit of the current character, so there is no idle gap between characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txc | input | 1 | Transmit bit clock, synchronous to clk and slower than clk/2 |
| cfg_sync | input | 1 | 1 = synchronous mode, 0 = framed asynchronous mode |
| cfg_rate | input | 2 | Asynchronous bit-time multiple: 0 = x1, 1 = x16, 2 or 3 = x64 |
| cfg_len | input | 2 | Data bits per character minus 5 |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits in asynchronous mode |
| tx_en | input | 1 | Transmit enable command bit |
| cts_n | input | 1 | Clear to send, active low |
| brk | input | 1 | Force the line low |
| in_valid | input | 1 | Host offers a byte |
| in_data | input | DATA_W | Byte offered by the host |
| in_ready | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register empty and transmission enabled |
| tx_empty | output | 1 | No character held and shifter idle |

## Verification
The bench builds the block with its defaults: an 8-bit data path, 5 as the shortest character, and multiples of 16 and 64. `txc` runs at a quarter of the system clock. At these sizes every character length, every parity setting and both stop counts can be swept in full, in synchronous mode and at the x1 and x16 rates. The x64 rate gets a few frames. The expected bit sequence is built arithmetically for each frame, and every `txc` period of every bit is compared against it. Separate scenarios cover back-to-back characters, disabling after a write, writes while disabled, and break.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int LEN_SEL_W = 2;

  typedef enum logic [1:0] {
    RATE_ONE    = 2'd0,
    RATE_MID    = 2'd1,
    RATE_HI     = 2'd2,
    RATE_HI_ALT = 2'd3
  } rate_e;
endpackage

// File: rtl/sertx_edge.sv
module sertx_edge (
  input  logic clk,
  input  logic rst,
  input  logic txc,
  output logic tick
);
  logic txc_q;

  always_ff @(posedge clk) begin
    if (rst) txc_q <= 1'b0;
    else     txc_q <= txc;
  end

  // one-cycle pulse after each high-to-low transition of txc
  assign tick = txc_q & ~txc;

  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              accept_en,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic accept;

  assign in_ready = ~full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (accept && accept_en) begin
      full <= 1'b1;
      data <= in_data;
    end
  end

  a_r9_drop_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (accept && !accept_en) |=> !full);

  a_r6_data_held: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/sertx_pacer.sv
module sertx_pacer
  import serial_tx_pkg::*;
#(
  parameter int RATE_MID_X = 16,
  parameter int RATE_HI_X  = 64,
  localparam int CNT_W = (RATE_HI_X > 1) ? $clog2(RATE_HI_X) : 1,
  localparam int LIM_W = CNT_W + 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  start,
  input  logic  busy,
  input  logic  sync_mode,
  input  rate_e rate,
  output logic  bit_end
);
  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic [LIM_W-1:0] lim_sel;

  always_comb begin
    if (sync_mode) begin
      lim_sel = LIM_W'(1);
    end else begin
      case (rate)
        RATE_ONE: lim_sel = LIM_W'(1);
        RATE_MID: lim_sel = LIM_W'(RATE_MID_X);
        default:  lim_sel = LIM_W'(RATE_HI_X);
      endcase
    end
  end

  assign bit_end = tick & busy & ({1'b0, cnt_q} == (lim_q - LIM_W'(1)));

  // the multiple is latched at frame start, so config may move mid-frame
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= LIM_W'(1);
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= lim_sel;
    end else if (tick && busy) begin
      cnt_q <= bit_end ? '0 : cnt_q + CNT_W'(1);
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, cnt_q} < lim_q));

  a_r2_count_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |-> $past(tick));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int FRAME_W = DATA_W + 4,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bit_end,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              sync_mode,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              start,
  output logic              busy,
  output logic              line_bit
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   left_q;
  logic [FRAME_W-1:0] fbits;
  logic [LEN_W-1:0]   flen;
  logic [LEN_W-1:0]   pos;
  logic               par;
  logic               last_end;
  int                 nbits;

  // assemble the outgoing frame, bit 0 first on the line
  always_comb begin
    fbits = '1;
    pos   = '0;
    par   = par_odd;
    nbits = MIN_BITS + int'(len_sel);
    if (nbits > DATA_W) nbits = DATA_W;
    if (!sync_mode) begin
      fbits[0] = 1'b0;
      pos      = LEN_W'(1);
    end
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        fbits[pos] = hold_data[i];
        par        = par ^ hold_data[i];
        pos        = pos + LEN_W'(1);
      end
    end
    if (par_en) begin
      fbits[pos] = par;
      pos        = pos + LEN_W'(1);
    end
    if (!sync_mode) pos = pos + (two_stop ? LEN_W'(2) : LEN_W'(1));
    flen = pos;
  end

  assign last_end = bit_end & (left_q == LEN_W'(1));
  assign start    = tick & hold_full & (~busy | last_end);
  assign line_bit = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
    end else if (start) begin
      sh_q   <= fbits;
      left_q <= flen;
      busy   <= 1'b1;
    end else if (bit_end) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - LEN_W'(1);
      if (last_end) busy <= 1'b0;
    end
  end

  a_r2_shift_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(sh_q) |-> $past(tick));

  a_r5_start_bit: assert property (@(posedge clk) disable iff (rst)
    (start && !sync_mode) |=> !line_bit);

  a_r12_no_gap: assert property (@(posedge clk) disable iff (rst)
    (last_end && hold_full) |=> busy);
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_BITS   = 5,
  parameter int RATE_MID_X = 16,
  parameter int RATE_HI_X  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txc,
  input  logic              cfg_sync,
  input  logic [1:0]        cfg_rate,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              brk,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);
  logic              tick;
  logic              start;
  logic              busy;
  logic              line_bit;
  logic              bit_end;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              en;
  rate_e             rate_sel;

  assign en       = tx_en & ~cts_n;
  assign rate_sel = rate_e'(cfg_rate);

  sertx_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .txc  (txc),
    .tick (tick)
  );

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .accept_en (en),
    .take      (start),
    .full      (hold_full),
    .data      (hold_data)
  );

  sertx_pacer #(.RATE_MID_X(RATE_MID_X), .RATE_HI_X(RATE_HI_X)) u_pacer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start     (start),
    .busy      (busy),
    .sync_mode (cfg_sync),
    .rate      (rate_sel),
    .bit_end   (bit_end)
  );

  sertx_shift #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bit_end   (bit_end),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .sync_mode (cfg_sync),
    .len_sel   (cfg_len),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .two_stop  (cfg_two_stop),
    .start     (start),
    .busy      (busy),
    .line_bit  (line_bit)
  );

  assign txd      = brk ? 1'b0 : (busy ? line_bit : 1'b1);
  assign tx_ready = ~hold_full & en;
  assign tx_empty = ~busy & ~hold_full;

  a_r7_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && tx_en && !cts_n) |=> !tx_ready);

  a_r8_kept_after_disable: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !en) |=> (hold_full || busy));
endmodule

// File: tb/tb_serial_tx.sv
module tb_serial_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txc = 1'b0;
  logic       cfg_sync = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       tx_en = 1'b1;
  logic       cts_n = 1'b0;
  logic       brk = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, tx_ready, tx_empty;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;
  bit  exp_b [0:31];
  int  exp_n = 0;
  int  txc_div = 0;

  serial_tx dut (
    .clk(clk), .rst(rst), .txc(txc), .cfg_sync(cfg_sync), .cfg_rate(cfg_rate),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .tx_en(tx_en), .cts_n(cts_n), .brk(brk),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd),
    .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #2.5 clk = ~clk;

  // txc period = 4 clk cycles, edges on falling clk
  always @(negedge clk) begin
    txc_div = txc_div + 1;
    if (txc_div == 2) begin
      txc_div = 0;
      txc = ~txc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic add_frame(input logic [7:0] d, input int lsel, input bit sy,
                           input bit pe, input bit po, input bit ts);
    int nb;
    bit p;
    nb = 5 + lsel;
    p  = po;
    if (!sy) begin exp_b[exp_n] = 1'b0; exp_n++; end
    for (int i = 0; i < nb; i++) begin
      exp_b[exp_n] = d[i];
      p = p ^ d[i];
      exp_n++;
    end
    if (pe) begin exp_b[exp_n] = p; exp_n++; end
    if (!sy) begin
      exp_b[exp_n] = 1'b1; exp_n++;
      if (ts) begin exp_b[exp_n] = 1'b1; exp_n++; end
    end
  endtask

  task automatic set_cfg(input bit sy, input int rate, input int lsel,
                         input bit pe, input bit po, input bit ts);
    @(negedge clk);
    cfg_sync = sy; cfg_rate = 2'(rate); cfg_len = 2'(lsel);
    cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
  endtask

  task automatic put(input logic [7:0] d);
    do @(negedge clk); while (!in_ready);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_empty();
    while (!tx_empty) @(negedge clk);
  endtask

  function automatic int mult_of(input bit sy, input int rate);
    if (sy || rate == 0) return 1;
    if (rate == 1) return 16;
    return 64;
  endfunction

  // compares every txc period of every expected bit
  task automatic capture(input int mult, input string req);
    int bad, st, em;
    logic s;
    bad = 0; st = 0; em = 0;
    for (int b = 0; b < exp_n; b++) begin
      for (int k = 0; k < mult; k++) begin
        @(posedge txc);
        if (txd !== exp_b[b]) bad++;
        if (tx_empty !== 1'b0) em++;
        s = txd;
        @(negedge txc);
        if (txd !== s) st++;
      end
    end
    check(bad == 0, req, bad, 0);
    check(st == 0, "R2 stable through txc high phase", st, 0);
    check(em == 0, "R10 empty low during frame", em, 0);
  endtask

  task automatic end_check();
    repeat (2) @(negedge clk);
    check(tx_empty === 1'b1 && txd === 1'b1, "R10 idle after frame",
          {tx_empty, txd}, 3);
  endtask

  task automatic run_frame(input logic [7:0] d, input bit sy, input int rate,
                           input int lsel, input bit pe, input bit po,
                           input bit ts, input string req);
    wait_empty();
    set_cfg(sy, rate, lsel, pe, po, ts);
    exp_n = 0;
    add_frame(d, lsel, sy, pe, po, ts);
    put(d);
    check(in_ready === 1'b0, "R6 ready low after accept", in_ready, 0);
    check(tx_ready === 1'b0, "R7 tx_ready low after write", tx_ready, 0);
    @(negedge txc);
    capture(mult_of(sy, rate), req);
    end_check();
  endtask

  task automatic watch_idle(input int periods, input string req);
    int bad;
    bad = 0;
    for (int k = 0; k < periods; k++) begin
      @(posedge txc);
      if (txd !== 1'b1 || tx_empty !== 1'b1) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    logic [7:0] d;
    int cnt;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 txd after reset", txd, 1);
    check(tx_empty === 1'b1, "R1 tx_empty after reset", tx_empty, 1);
    check(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(tx_ready === 1'b1, "R1 tx_ready after reset", tx_ready, 1);

    // R3 synchronous sweep
    for (int l = 0; l < 4; l++)
      for (int pc = 0; pc < 3; pc++)
        for (int v = 0; v < 2; v++) begin
          d = 8'h5A ^ 8'(l * 49 + pc * 15 + v * 195);
          run_frame(d, 1'b1, 0, l, pc != 0, pc == 2, 1'b0, "R3 sync bits");
        end

    // R5 asynchronous frame sweep at x1
    for (int l = 0; l < 4; l++)
      for (int pc = 0; pc < 3; pc++)
        for (int ts = 0; ts < 2; ts++) begin
          d = 8'hC3 ^ 8'(l * 37 + pc * 90 + ts * 7);
          run_frame(d, 1'b0, 0, l, pc != 0, pc == 2, ts != 0, "R5 async frame");
        end

    // R4 bit-time multiples
    for (int l = 0; l < 4; l++)
      for (int pc = 0; pc < 3; pc++)
        for (int ts = 0; ts < 2; ts++) begin
          d = 8'h2B ^ 8'(l * 71 + pc * 23 + ts * 129);
          run_frame(d, 1'b0, 1, l, pc != 0, pc == 2, ts != 0, "R4 x16 frame");
        end
    run_frame(8'h96, 1'b0, 2, 3, 1'b1, 1'b0, 1'b1, "R4 x64 frame");
    run_frame(8'h0D, 1'b0, 3, 0, 1'b0, 1'b0, 1'b0, "R4 x64 alt code");

    // R12 back-to-back characters
    wait_empty();
    set_cfg(1'b1, 0, 3, 1'b0, 1'b0, 1'b0);
    exp_n = 0;
    add_frame(8'hE1, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    add_frame(8'h3C, 3, 1'b1, 1'b0, 1'b0, 1'b0);
    put(8'hE1);
    @(negedge txc);
    fork
      capture(1, "R12 no gap between characters");
      put(8'h3C);
    join
    end_check();

    // R8 disable by cts_n after the write
    wait_empty();
    set_cfg(1'b0, 0, 3, 1'b1, 1'b1, 1'b0);
    exp_n = 0;
    add_frame(8'h81, 3, 1'b0, 1'b1, 1'b1, 1'b0);
    put(8'h81);
    cts_n = 1'b1;
    @(negedge clk);
    check(tx_ready === 1'b0, "R7 tx_ready low with cts_n high", tx_ready, 0);
    @(negedge txc);
    capture(1, "R8 sent after cts disable");
    end_check();
    cts_n = 1'b0;

    // R8 disable by command after the write
    exp_n = 0;
    add_frame(8'h4E, 3, 1'b0, 1'b1, 1'b1, 1'b0);
    put(8'h4E);
    tx_en = 1'b0;
    @(negedge txc);
    capture(1, "R8 sent after command disable");
    end_check();

    // R9 write while disabled is dropped
    check(tx_ready === 1'b0, "R7 tx_ready low while disabled", tx_ready, 0);
    check(in_ready === 1'b1, "R6 in_ready while disabled", in_ready, 1);
    put(8'h00);
    @(negedge clk);
    check(in_ready === 1'b1, "R9 holding stays empty", in_ready, 1);
    watch_idle(40, "R9 dropped while disabled");
    tx_en = 1'b1;
    watch_idle(30, "R9 not sent after re-enable");
    check(tx_ready === 1'b1, "R7 tx_ready back when enabled", tx_ready, 1);

    // R11 break at idle
    @(negedge clk);
    brk = 1'b1;
    cnt = 0;
    repeat (20) begin
      @(negedge clk);
      if (txd !== 1'b0) cnt++;
    end
    check(cnt == 0, "R11 break at idle", cnt, 0);
    brk = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R11 line returns high", txd, 1);

    // R11 break during a frame of ones
    set_cfg(1'b0, 1, 3, 1'b0, 1'b0, 1'b0);
    put(8'hFF);
    @(negedge txc);
    repeat (10) @(negedge clk);
    brk = 1'b1;
    cnt = 0;
    repeat (100) begin
      @(negedge clk);
      if (txd !== 1'b0) cnt++;
    end
    check(cnt == 0, "R11 break during frame", cnt, 0);
    brk = 1'b0;
    wait_empty();
    end_check();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule